// File: doc/BRIEF.md
# LCD Icon Segment Mapper Engine

This engine turns operations on logical display icons into bit updates in the segment data registers of a multiplexed LCD controller. An icon is a seven-segment digit, a group of decimal points or a group of colons. Its segments may be spread over many segment registers and several commons. A table computed at elaboration time gives each icon a segment count and a list of map bytes. Each map byte names one common and one segment driver.

A write command walks the icon's list and sets or clears one common bit per entry, under control of a bit mask. A read command walks the same list and builds a mask from the stored segment data. A control command clears all segment data or switches the display enable. The segment register file sits outside the engine. The engine reaches it through a single read-modify-write port: an address, combinational read data, a write strobe and write data.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A command presented while `cmd_ready` is low is not taken, and the source must hold it or drop it. No buffering exists at the edge. The result has no back-pressure: `rd_mask` is valid from the `done` pulse until the next command is accepted.

Top module: `iseg_engine`

## Requirements
- R1: A map byte holds the common index in bits [7:6] and the segment-driver index (register address) in bits [5:0]. Common k controls bit k of the 4-bit segment word.
- R2: Icons 0 to 7 have 7 entries each, and entry i uses common (i mod 3) and driver 3*icon + i/3. Icon 8 has 7 entries, and entry i uses common 3 and driver 3*i. Icon 9 has 3 entries, and entry i uses common 3 and driver 40+i.
- R3: A write command (cmd_op=0) sets the entry-i common bit when cmd_mask[i]=1 and clears it when cmd_mask[i]=0. All other bits of every register are unchanged, and mask bits at or above the icon's count are ignored.
- R4: A read command (cmd_op=1) returns rd_mask with bit i equal to the stored entry-i common bit. Bits at or above the count are 0, and the command performs no write.
- R5: Entries that share a segment register see the updates made by earlier entries in the same walk.
- R6: A control command (cmd_op=2) whose code has bit 0 set writes 0 to all 64 segment registers and leaves disp_en unchanged.
- R7: A control code with bit 0 clear sets disp_en when it equals 0x0C and clears disp_en for any other value.
- R8: cmd_ready is low while busy is high, and a command offered then is ignored. done is a one-cycle pulse given while busy is still high.
- R9: An icon number of 10 or more gives rd_mask 0 on a read and changes nothing on a write. done still follows.
- R10: Counting the first cycle after acceptance as cycle 1, done is high in cycle 2n+1 for a write of n entries, in cycle n+1 for a read, in cycle 65 for a clear, and in cycle 1 for any other control or out-of-range command.
- R11: After reset, busy, done, seg_we, disp_en and rd_mask are 0 and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 write icon, 1 read icon, 2 control, 3 no operation |
| cmd_icon | input | 4 | Icon number |
| cmd_mask | input | 16 | Segment mask for write, bit i for entry i |
| cmd_code | input | 8 | Control code |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_mask | output | 16 | Result of the last read |
| disp_en | output | 1 | Display enable |
| seg_addr | output | 6 | Segment register address |
| seg_rdata | input | 4 | Data of the addressed register, combinational |
| seg_we | output | 1 | Write strobe |
| seg_wdata | output | 4 | Write data |

## Verification
The bench drives icon 0 because its first three entries share register 0 on different commons. A design that pipelined its read-modify-write cycles would lose one of those bits. The decimal-point icon shares drivers with the digits, so an update that touched the neighbouring commons would corrupt digit bits. The bench also writes a three-entry icon with a mask whose high bits are set, to catch a design that walked past the count. Busy-time commands, out-of-range icon numbers and the odd clear code 0x0D are checked at the ports, each with its cycle count.

// File: rtl/iseg_pkg.sv
package iseg_pkg;
  localparam int DRV_W = 6;
  localparam int COM_W = 2;
  localparam int WORD_W = 4;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_CTL = 2'd2, OP_NOP = 2'd3} op_e;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_CLR, S_FIN} st_e;

  // Map byte for entry i of an icon: {common, driver}
  function automatic logic [7:0] map_byte(int icon, int i);
    int com;
    int drv;
    if (icon < 8) begin
      com = i % 3;
      drv = 3 * icon + i / 3;
    end else if (icon == 8) begin
      com = 3;
      drv = 3 * i;
    end else begin
      com = 3;
      drv = 40 + i;
    end
    return {COM_W'(com), DRV_W'(drv)};
  endfunction

  function automatic int map_count(int icon);
    if (icon <= 8) return 7;
    if (icon == 9) return 3;
    return 0;
  endfunction
endpackage

// File: rtl/iseg_icon_rom.sv
module iseg_icon_rom
  import iseg_pkg::*;
#(
  parameter int NUM_ICONS = 10,
  parameter int MAX_SEGS  = 16,
  parameter int ICON_W    = 4,
  localparam int SLOT_W   = $clog2(MAX_SEGS),
  localparam int IDX_W    = SLOT_W + 1
) (
  input  logic [ICON_W-1:0] icon,
  input  logic [SLOT_W-1:0] slot,
  output logic              hit,
  output logic [IDX_W-1:0]  cnt,
  output logic [7:0]        mbyte
);
  logic [7:0]       tbl     [NUM_ICONS][MAX_SEGS];
  logic [IDX_W-1:0] cnt_tbl [NUM_ICONS];

  for (genvar gi = 0; gi < NUM_ICONS; gi++) begin : g_icon
    assign cnt_tbl[gi] = IDX_W'(map_count(gi));
    for (genvar gs = 0; gs < MAX_SEGS; gs++) begin : g_slot
      assign tbl[gi][gs] = map_byte(gi, gs);
    end
  end

  always_comb begin
    hit   = 1'b0;
    cnt   = '0;
    mbyte = '0;
    for (int k = 0; k < NUM_ICONS; k++) begin
      if (icon == ICON_W'(k)) begin
        hit   = 1'b1;
        cnt   = cnt_tbl[k];
        mbyte = tbl[k][slot];
      end
    end
  end
endmodule

// File: rtl/iseg_bitpatch.sv
module iseg_bitpatch
  import iseg_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic [COM_W-1:0]  com,
  input  logic              val,
  output logic [WORD_W-1:0] word_out,
  output logic              bit_out
);
  logic [WORD_W-1:0] sel;
  assign sel      = WORD_W'(1) << com;
  assign word_out = val ? (word_in | sel) : (word_in & ~sel);
  assign bit_out  = |(word_in & sel);
endmodule

// File: rtl/iseg_engine.sv
module iseg_engine
  import iseg_pkg::*;
#(
  parameter int NUM_ICONS = 10,
  parameter int MAX_SEGS  = 16,
  parameter int SEG_REGS  = 64,
  parameter int ICON_W    = 4,
  localparam int SLOT_W   = $clog2(MAX_SEGS),
  localparam int IDX_W    = SLOT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [ICON_W-1:0]   cmd_icon,
  input  logic [MAX_SEGS-1:0] cmd_mask,
  input  logic [7:0]          cmd_code,
  output logic                busy,
  output logic                done,
  output logic [MAX_SEGS-1:0] rd_mask,
  output logic                disp_en,
  output logic [DRV_W-1:0]    seg_addr,
  input  logic [WORD_W-1:0]   seg_rdata,
  output logic                seg_we,
  output logic [WORD_W-1:0]   seg_wdata
);
  st_e                 state;
  logic [1:0]          op_q;
  logic [ICON_W-1:0]   icon_q;
  logic [MAX_SEGS-1:0] mask_q;
  logic [IDX_W-1:0]    idx_q;
  logic [DRV_W-1:0]    clr_ptr;
  logic [WORD_W-1:0]   rbuf;
  logic [MAX_SEGS-1:0] res;
  logic                en;

  logic [ICON_W-1:0]   rom_icon;
  logic                rom_hit;
  logic [IDX_W-1:0]    rom_cnt;
  logic [7:0]          rom_byte;
  logic [SLOT_W-1:0]   slot;
  logic [WORD_W-1:0]   patch_in, patch_out;
  logic                patch_bit, last;

  assign slot     = idx_q[SLOT_W-1:0];
  assign rom_icon = (state == S_IDLE) ? cmd_icon : icon_q;
  assign last     = (idx_q + 1'b1) == rom_cnt;
  assign patch_in = (state == S_WR) ? rbuf : seg_rdata;

  iseg_icon_rom #(.NUM_ICONS(NUM_ICONS), .MAX_SEGS(MAX_SEGS), .ICON_W(ICON_W)) u_rom (
    .icon(rom_icon), .slot(slot), .hit(rom_hit), .cnt(rom_cnt), .mbyte(rom_byte)
  );

  iseg_bitpatch u_patch (
    .word_in(patch_in), .com(rom_byte[7 -: COM_W]), .val(mask_q[slot]),
    .word_out(patch_out), .bit_out(patch_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_NOP;
      icon_q  <= '0;
      mask_q  <= '0;
      idx_q   <= '0;
      clr_ptr <= '0;
      rbuf    <= '0;
      res     <= '0;
      en      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          icon_q <= cmd_icon;
          mask_q <= cmd_mask;
          idx_q  <= '0;
          res    <= '0;
          case (op_e'(cmd_op))
            OP_WR, OP_RD: state <= (rom_hit && rom_cnt != '0) ? S_RD : S_FIN;
            OP_CTL: begin
              if (cmd_code[0]) begin
                clr_ptr <= '0;
                state   <= S_CLR;
              end else begin
                en    <= (cmd_code == 8'h0C);
                state <= S_FIN;
              end
            end
            default: state <= S_FIN;
          endcase
        end
        S_RD: begin
          if (op_q == OP_RD) begin
            res[slot] <= patch_bit;
            idx_q     <= idx_q + 1'b1;
            state     <= last ? S_FIN : S_RD;
          end else begin
            rbuf  <= seg_rdata;
            state <= S_WR;
          end
        end
        S_WR: begin
          idx_q <= idx_q + 1'b1;
          state <= last ? S_FIN : S_RD;
        end
        S_CLR: begin
          clr_ptr <= clr_ptr + 1'b1;
          if (clr_ptr == DRV_W'(SEG_REGS - 1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign rd_mask   = res;
  assign disp_en   = en;
  assign seg_we    = (state == S_WR) || (state == S_CLR);
  assign seg_addr  = (state == S_CLR) ? clr_ptr : rom_byte[DRV_W-1:0];
  assign seg_wdata = (state == S_CLR) ? '0 : patch_out;

  // R8: never ready while a command is in progress
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  // R8: done is a single-cycle pulse inside the busy window
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 !done);
  // R5: the write of a read-modify-write goes to the address just read
  a_r5_rmw_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) |-> (seg_addr == $past(seg_addr)) && $past(state == S_RD));
  // R4: a read walk never writes
  a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RD) |-> !seg_we);
  // R6: clearing writes only zeros
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CLR) |-> seg_we && seg_wdata == '0);
  // R3: a patch changes at most one common bit of the word read
  a_r3_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) |-> $countones(seg_wdata ^ rbuf) <= 1);
endmodule

// File: tb/iseg_engine_tb.sv
module iseg_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_icon = '0;
  logic [15:0] cmd_mask = '0;
  logic [7:0]  cmd_code = '0;
  logic        busy, done, disp_en, seg_we;
  logic [15:0] rd_mask;
  logic [5:0]  seg_addr;
  logic [3:0]  seg_rdata, seg_wdata;

  logic [3:0] segmem [64];
  logic [3:0] expm   [64];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iseg_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_icon(cmd_icon), .cmd_mask(cmd_mask), .cmd_code(cmd_code),
    .busy(busy), .done(done), .rd_mask(rd_mask), .disp_en(disp_en),
    .seg_addr(seg_addr), .seg_rdata(seg_rdata), .seg_we(seg_we), .seg_wdata(seg_wdata)
  );

  assign seg_rdata = segmem[seg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) segmem[k] <= 4'(k * 5 + 3);
    end else if (seg_we) begin
      segmem[seg_addr] <= seg_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // icon table as stated in R2
  function automatic int ref_count(int icon);
    if (icon < 9) return 7;
    if (icon == 9) return 3;
    return 0;
  endfunction
  function automatic int ref_com(int icon, int i);
    return (icon < 8) ? i % 3 : 3;
  endfunction
  function automatic int ref_drv(int icon, int i);
    if (icon < 8) return icon * 3 + i / 3;
    if (icon == 8) return i * 3;
    return 40 + i;
  endfunction

  task automatic ref_write(input int icon, input logic [15:0] m);
    for (int i = 0; i < ref_count(icon); i++)
      expm[ref_drv(icon, i)][ref_com(icon, i)] = m[i];
  endtask
  function automatic logic [15:0] ref_read(int icon);
    logic [15:0] r = '0;
    for (int i = 0; i < ref_count(icon); i++) r[i] = expm[ref_drv(icon, i)][ref_com(icon, i)];
    return r;
  endfunction

  task automatic cmp_mem(input string req, input string what);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < 64; k++)
      if (segmem[k] !== expm[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    if (first < 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, {what, " reg"}, int'(segmem[first]), int'(expm[first]));
  endtask

  task automatic do_cmd(input logic [1:0] op, input int icon, input logic [15:0] m,
                        input logic [7:0] code, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_icon = 4'(icon); cmd_mask = m; cmd_code = code;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    check(busy == 1'b0 && done == 1'b0 && seg_we == 1'b0, "R11", "busy/done/we", {busy, done, seg_we}, 0);
    check(cmd_ready == 1'b1, "R11", "ready", cmd_ready, 1);
    check(disp_en == 1'b0 && rd_mask == '0, "R11", "en/rd_mask", {disp_en, rd_mask}, 0);
  endtask

  task automatic t_write_read;
    int c;
    do_cmd(2'd0, 2, 16'h0055, 8'h00, c);
    ref_write(2, 16'h0055);
    check(c == 15, "R10", "write cycles", c, 15);
    cmp_mem("R3", "write icon 2");
    do_cmd(2'd1, 2, 16'h0000, 8'h00, c);
    check(c == 8, "R10", "read cycles", c, 8);
    check(rd_mask == 16'h0055, "R4", "read icon 2", rd_mask, 16'h0055);
    do_cmd(2'd1, 5, 16'h0000, 8'h00, c);
    check(rd_mask == ref_read(5), "R4", "read icon 5 preload", rd_mask, ref_read(5));
    cmp_mem("R4", "read leaves data");
  endtask

  task automatic t_shared;
    int c;
    do_cmd(2'd0, 0, 16'h0007, 8'h00, c);
    ref_write(0, 16'h0007);
    check(segmem[0][2:0] == 3'b111, "R5", "shared reg set", segmem[0], expm[0]);
    do_cmd(2'd0, 0, 16'h0002, 8'h00, c);
    ref_write(0, 16'h0002);
    check(segmem[0] == expm[0], "R5", "shared reg mix", segmem[0], expm[0]);
    cmp_mem("R1", "common bit positions");
  endtask

  task automatic t_overlay;
    int c;
    do_cmd(2'd0, 8, 16'h007F, 8'h00, c);
    ref_write(8, 16'h007F);
    cmp_mem("R2", "dp icon on common 3");
    do_cmd(2'd0, 9, 16'hFFF8, 8'h00, c);
    ref_write(9, 16'hFFF8);
    check(c == 7, "R10", "short icon cycles", c, 7);
    cmp_mem("R3", "mask bits above count");
    do_cmd(2'd1, 9, 16'h0000, 8'h00, c);
    check(rd_mask == 16'h0000, "R4", "read short icon", rd_mask, 0);
  endtask

  task automatic t_out_of_range;
    int c;
    do_cmd(2'd0, 12, 16'hFFFF, 8'h00, c);
    check(c == 1, "R9", "oor write cycles", c, 1);
    cmp_mem("R9", "oor write no change");
    do_cmd(2'd1, 1, 16'h0000, 8'h00, c);
    do_cmd(2'd1, 15, 16'h0000, 8'h00, c);
    check(rd_mask == 16'h0000 && c == 1, "R9", "oor read", rd_mask, 0);
  endtask

  task automatic t_busy;
    int c;
    bit rdy_seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_icon = 4'd1; cmd_mask = 16'h007F;
    @(posedge clk);
    @(negedge clk);
    cmd_icon = 4'd5;
    for (int k = 0; k < 3; k++) begin
      if (cmd_ready) rdy_seen = 1'b1;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    c = 0;
    while (!done && c < 200) begin
      @(negedge clk);
      c++;
    end
    ref_write(1, 16'h007F);
    check(!rdy_seen, "R8", "ready during busy", rdy_seen, 0);
    check(done && busy, "R8", "done inside busy", {done, busy}, 3);
    @(negedge clk);
    check(!done && !busy, "R8", "done one cycle", {done, busy}, 0);
    cmp_mem("R8", "busy command ignored");
  endtask

  task automatic t_ctrl;
    int c;
    do_cmd(2'd2, 0, 16'h0000, 8'h0C, c);
    check(disp_en == 1'b1 && c == 1, "R7", "code 0C on", disp_en, 1);
    do_cmd(2'd2, 0, 16'h0000, 8'h08, c);
    check(disp_en == 1'b0, "R7", "code 08 off", disp_en, 0);
    do_cmd(2'd2, 0, 16'h0000, 8'h0C, c);
    do_cmd(2'd2, 0, 16'h0000, 8'h42, c);
    check(disp_en == 1'b0, "R7", "code 42 off", disp_en, 0);
    cmp_mem("R7", "control leaves data");
  endtask

  task automatic t_clear;
    int c;
    do_cmd(2'd2, 0, 16'h0000, 8'h0C, c);
    do_cmd(2'd2, 0, 16'h0000, 8'h01, c);
    for (int k = 0; k < 64; k++) expm[k] = '0;
    check(c == 65, "R10", "clear cycles", c, 65);
    cmp_mem("R6", "clear zeroes all");
    check(disp_en == 1'b1, "R6", "clear keeps enable", disp_en, 1);
    do_cmd(2'd0, 3, 16'h007F, 8'h00, c);
    ref_write(3, 16'h007F);
    do_cmd(2'd2, 0, 16'h0000, 8'h0D, c);
    for (int k = 0; k < 64; k++) expm[k] = '0;
    cmp_mem("R6", "odd code 0D clears");
    check(disp_en == 1'b1, "R6", "0D keeps enable", disp_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) expm[k] = 4'(k * 5 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_shared();
    t_overlay();
    t_out_of_range();
    t_busy();
    t_ctrl();
    t_clear();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule